// File: doc/BRIEF.md
# Sixteen-Byte-per-Cycle CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a message that arrives 128 bits at a time, one beat per clock. Each beat is split into four 32-bit words. Three of the words pass through fixed GF(2) matrices that carry each one forward by the number of message bits that follow it in the beat. The fourth word, which has no bits after it, goes through unchanged. The running remainder from earlier beats is carried forward by a full beat through a fifth matrix, and all of these terms are XORed into the new remainder.

Stage one computes the four word mappings and registers them as two pairwise XOR sums. Stage two adds the advanced feedback term and updates the remainder. Every matrix is computed during elaboration by a constant function that repeats a single multiply-by-x step, so no table is stored anywhere. The CRC output is the remainder carried forward by 32 more zero bits. That value equals the result of a bit-serial shift register that starts from zero, takes the first beat's bit 127 first, uses no reflection and applies no final inversion.

A host marks the first beat of a message with a start flag and the final beat with a last flag. It then reads the result on the cycle where the done pulse appears.

Top module: `crc32_table_pipe`

## Requirements
- R1: The generator is x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1 (0x04C11DB7 without the top term). For a message M, crc_o equals M(x)·x^32 mod G(x). The first beat's data_i[127] is the highest-order message bit, bits within a beat run from 127 down to 0, and later beats have lower order.
- R2: A beat is taken on each clock edge where valid_i is high. Beats may arrive on consecutive cycles, and messages may follow each other with no idle cycle between them.
- R3: done_o is high for exactly one cycle for each beat accepted with last_i high. It rises in the second cycle after that beat's cycle, and in that cycle crc_o holds the CRC of the message.
- R4: A beat accepted with start_i high begins a new message. Any remainder accumulated by earlier beats, including those of an unfinished message, has no effect on the result.
- R5: start_i high with valid_i low clears the remainder, and crc_o reads 0 in the second cycle after it. A later beat sent without start_i then continues from that cleared state.
- R6: crc_o does not change while no beat and no clear has been accepted in the cycle two cycles earlier.
- R7: After a synchronous active-low reset, done_o is 0 and crc_o is 0.
- R8: Idle cycles with valid_i low between the beats of a message do not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | A data beat is present |
| start_i | input | 1 | First beat of a message, or a clear when valid_i is low |
| last_i | input | 1 | Final beat of a message |
| data_i | input | 128 | Message beat, bit 127 is first in order |
| crc_o | output | 32 | CRC of the message so far |
| done_o | output | 1 | One-cycle pulse: crc_o is final for the message |

## Verification
The bench sweeps all 128 single-bit one-beat messages. A mapping matrix with a wrong shift count or a swapped word would give a wrong CRC for every bit position in the affected word. Random multi-beat messages with and without idle gaps test the feedback matrix; an advance by the wrong distance only shows up from the second beat onward. Abandoned messages followed by a new start, and a bare clear followed by a message sent without start, check that stale remainders are dropped; a design that ignored start would return a CRC polluted by the earlier beats. The cycle of each done pulse is compared with the cycle of its last beat to catch any latency that is one cycle off.

// File: rtl/crc32_pipe_pkg.sv
// Shared constants and the constant functions that build the zero-advance
// matrices. Assumes a 32-bit non-reflected CRC with the generator below.
package crc32_pipe_pkg;

    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] GEN_POLY = 32'h04C1_1DB7;

    // Column j of a matrix is the image of basis vector e_j.
    typedef logic [CRC_W*CRC_W-1:0] adv_mat_t;

    // Multiply a remainder by x modulo the generator.
    function automatic logic [CRC_W-1:0] mul_x(input logic [CRC_W-1:0] s);
        logic [CRC_W-1:0] sh;
        sh = {s[CRC_W-2:0], 1'b0};
        return s[CRC_W-1] ? (sh ^ GEN_POLY) : sh;
    endfunction

    // Build the matrix that multiplies a remainder by x^nbits modulo G.
    function automatic adv_mat_t build_adv_mat(input int nbits);
        adv_mat_t m;
        logic [CRC_W-1:0] col;
        m = '0;
        for (int j = 0; j < CRC_W; j++) begin
            col = '0;
            col[j] = 1'b1;
            for (int k = 0; k < nbits; k++) begin
                col = mul_x(col);
            end
            m[j*CRC_W +: CRC_W] = col;
        end
        return m;
    endfunction

endpackage

// File: rtl/crc_zero_adv.sv
// Combinational GF(2) matrix: carries a remainder forward by SHIFT_BITS zero
// bits, i.e. multiplies it by x^SHIFT_BITS mod G. The matrix is a constant
// computed at elaboration. Assumes SHIFT_BITS >= 0.
module crc_zero_adv #(
    parameter int SHIFT_BITS = 32
) (
    input  logic [crc32_pipe_pkg::CRC_W-1:0] vec_i,
    output logic [crc32_pipe_pkg::CRC_W-1:0] vec_o
);
    import crc32_pipe_pkg::*;

    localparam adv_mat_t ADV_MAT = build_adv_mat(SHIFT_BITS);

    // XOR together the columns selected by the set input bits.
    always_comb begin
        vec_o = '0;
        for (int j = 0; j < CRC_W; j++) begin
            if (vec_i[j]) begin
                vec_o = vec_o ^ ADV_MAT[j*CRC_W +: CRC_W];
            end
        end
    end

endmodule

// File: rtl/crc_blk_stage.sv
// Pipeline stage one. Splits a beat into CRC_W-bit words; word i (counted from
// the least significant end) is advanced by i*CRC_W bits, word 0 is passed as
// is. Adjacent mapped words are XORed in pairs (the pre-XOR) and registered
// together with the control flags. Assumes DATA_W is an even multiple of CRC_W.
module crc_blk_stage #(
    parameter int DATA_W = 128
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  valid_i,
    input  logic                                  start_i,
    input  logic                                  last_i,
    input  logic [DATA_W-1:0]                     data_i,
    output logic                                  s1_vld,
    output logic                                  s1_first,
    output logic                                  s1_last,
    output logic                                  s1_clr,
    output logic [DATA_W/(2*crc32_pipe_pkg::CRC_W)-1:0][crc32_pipe_pkg::CRC_W-1:0] s1_part
);
    import crc32_pipe_pkg::*;

    localparam int NBLK  = DATA_W / CRC_W;
    localparam int NPAIR = NBLK / 2;

    logic [NBLK-1:0][CRC_W-1:0]  blk_map;
    logic [NPAIR-1:0][CRC_W-1:0] pair_sum;

    // One mapping per word; the lowest word needs none.
    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        if (i == 0) begin : g_direct
            assign blk_map[i] = data_i[CRC_W-1:0];
        end else begin : g_mapped
            crc_zero_adv #(.SHIFT_BITS(i*CRC_W)) u_adv (
                .vec_i (data_i[i*CRC_W +: CRC_W]),
                .vec_o (blk_map[i])
            );
        end
    end

    // Pre-XOR of neighbouring word contributions.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_sum[p] = blk_map[2*p] ^ blk_map[2*p+1];
    end

    // Register the pre-XOR results and the beat flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_clr   <= 1'b0;
            s1_part  <= '0;
        end else begin
            s1_vld   <= valid_i;
            s1_first <= valid_i & start_i;
            s1_last  <= valid_i & last_i;
            s1_clr   <= ~valid_i & start_i;
            s1_part  <= pair_sum;
        end
    end

endmodule

// File: rtl/crc_acc_stage.sv
// Pipeline stage two. Carries the stored remainder forward by one full beat,
// XORs in the pre-XOR sums from stage one and stores the new remainder. A
// first beat or a clear discards the stored remainder. Raises a one-cycle
// done flag when a last beat is absorbed.
module crc_acc_stage #(
    parameter int DATA_W = 128
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  s1_vld,
    input  logic                                  s1_first,
    input  logic                                  s1_last,
    input  logic                                  s1_clr,
    input  logic [DATA_W/(2*crc32_pipe_pkg::CRC_W)-1:0][crc32_pipe_pkg::CRC_W-1:0] s1_part,
    output logic [crc32_pipe_pkg::CRC_W-1:0]      rem_q,
    output logic                                  done_q
);
    import crc32_pipe_pkg::*;

    localparam int NPAIR = DATA_W / (2*CRC_W);

    logic [CRC_W-1:0] rem_adv;
    logic [CRC_W-1:0] part_fold;
    logic [CRC_W-1:0] rem_next;

    // Advance the stored remainder over one beat of zero bits.
    crc_zero_adv #(.SHIFT_BITS(DATA_W)) u_fb_adv (
        .vec_i (rem_q),
        .vec_o (rem_adv)
    );

    // Fold the pre-XOR sums into a single term.
    always_comb begin
        part_fold = '0;
        for (int p = 0; p < NPAIR; p++) begin
            part_fold = part_fold ^ s1_part[p];
        end
    end

    // Combine with feedback, dropping it on the first beat of a message.
    always_comb begin
        rem_next = part_fold ^ (s1_first ? '0 : rem_adv);
    end

    // Update the remainder and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= s1_vld & s1_last;
            if (s1_vld) begin
                rem_q <= rem_next;
            end else if (s1_clr) begin
                rem_q <= '0;
            end
        end
    end

endmodule

// File: rtl/crc32_table_pipe.sv
// Top of the two-stage CRC-32 engine: one 128-bit beat per clock. The output
// is the stored remainder advanced by CRC_W zero bits, which turns the
// unaugmented remainder into the standard CRC.
module crc32_table_pipe #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              start_i,
    input  logic              last_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [31:0]       crc_o,
    output logic              done_o
);
    import crc32_pipe_pkg::*;

    localparam int NPAIR = DATA_W / (2*CRC_W);

    logic                            s1_vld;
    logic                            s1_first;
    logic                            s1_last;
    logic                            s1_clr;
    logic [NPAIR-1:0][CRC_W-1:0]     s1_part;
    logic [CRC_W-1:0]                rem_q;

    crc_blk_stage #(.DATA_W(DATA_W)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .start_i  (start_i),
        .last_i   (last_i),
        .data_i   (data_i),
        .s1_vld   (s1_vld),
        .s1_first (s1_first),
        .s1_last  (s1_last),
        .s1_clr   (s1_clr),
        .s1_part  (s1_part)
    );

    crc_acc_stage #(.DATA_W(DATA_W)) u_stage2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_vld   (s1_vld),
        .s1_first (s1_first),
        .s1_last  (s1_last),
        .s1_clr   (s1_clr),
        .s1_part  (s1_part),
        .rem_q    (rem_q),
        .done_q   (done_o)
    );

    // Convert the remainder into the augmented CRC value.
    crc_zero_adv #(.SHIFT_BITS(CRC_W)) u_out_adv (
        .vec_i (rem_q),
        .vec_o (crc_o)
    );

endmodule

// File: rtl/crc32_table_pipe_chk.sv
// Protocol and timing checks on the engine's ports, bound to the top module.
module crc32_table_pipe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic        start_i,
    input logic        last_i,
    input logic [31:0] crc_o,
    input logic        done_o
);

    // A done pulse always traces back to a last beat two cycles earlier.
    assert_done_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_i && last_i, 2));

    // Every last beat yields a done pulse two cycles later.
    assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && last_i) |-> ##2 done_o);

    // A bare clear shows a zero CRC two cycles later.
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_i) |-> ##2 (crc_o == 32'h0));

    // With no beat or clear two cycles back, the CRC holds.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(valid_i, 2) && !$past(start_i, 2)) |-> $stable(crc_o));

    // Reset leaves done low and the CRC at zero.
    assert_reset_state_R7: assert property (@(posedge clk)
        !rst_n |=> (!done_o && crc_o == 32'h0));

endmodule

bind crc32_table_pipe crc32_table_pipe_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .start_i (start_i),
    .last_i  (last_i),
    .crc_o   (crc_o),
    .done_o  (done_o)
);

// File: tb/crc32_table_pipe_test.sv
`timescale 1ns/1ps
module crc32_table_pipe_test;

    localparam logic [31:0] G = 32'h04C1_1DB7;
    localparam int MAXB = 16;
    localparam int MAXQ = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic         start_i = 1'b0;
    logic         last_i = 1'b0;
    logic [127:0] data_i = '0;
    logic [31:0]  crc_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr = 0;
    int rd = 0;
    bit finished = 1'b0;

    logic [127:0] msg [MAXB];
    logic [31:0]  exp_crc [MAXQ];
    int           exp_cyc [MAXQ];

    crc32_table_pipe uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .start_i(start_i),
        .last_i(last_i), .data_i(data_i), .crc_o(crc_o), .done_o(done_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, expv);
        end
    endtask

    // Bit-serial reference: message bits in order, start from zero.
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] s = '0;
        for (int i = 0; i < n; i++) begin
            for (int b = 127; b >= 0; b--) begin
                logic fb;
                fb = s[31] ^ msg[i][b];
                s = {s[30:0], 1'b0} ^ (fb ? G : 32'h0);
            end
        end
        return s;
    endfunction

    // Check each done pulse against the expected value and cycle (R1 R2 R3).
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (rd >= wr) begin
                check(1'b0, "R3 unexpected done", 32'h1, 32'h0);
            end else begin
                check(crc_o == exp_crc[rd], "R1 crc value", crc_o, exp_crc[rd]);
                check(cyc == exp_cyc[rd], "R3 done cycle", cyc, exp_cyc[rd]);
                rd++;
            end
        end
    end

    task automatic send_msg(input int n, input int gap_max, input bit use_start);
        for (int i = 0; i < n; i++) begin
            valid_i = 1'b1;
            start_i = use_start && (i == 0);
            last_i  = (i == n - 1);
            data_i  = msg[i];
            if (i == n - 1) begin
                exp_crc[wr] = ref_crc(n);
                exp_cyc[wr] = cyc + 2;
                wr++;
            end
            @(negedge clk);
            valid_i = 1'b0;
            start_i = 1'b0;
            last_i  = 1'b0;
            if (gap_max > 0) repeat ($urandom_range(gap_max, 0)) @(negedge clk);
        end
    endtask

    task automatic fill_random(input int n);
        for (int i = 0; i < n; i++) msg[i] = {$urandom, $urandom, $urandom, $urandom};
    endtask

    initial begin
        logic [31:0] held;
        repeat (4) @(negedge clk);
        // R7: reset state
        check(done_o == 1'b0, "R7 done after reset", {31'b0, done_o}, 32'h0);
        check(crc_o == 32'h0, "R7 crc after reset", crc_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every single-bit one-beat message, back to back
        for (int b = 0; b < 128; b++) begin
            msg[0] = '0;
            msg[0][b] = 1'b1;
            send_msg(1, 0, 1'b1);
        end
        // R1: all-zero and all-one beats
        msg[0] = '0; msg[1] = '0;
        send_msg(2, 0, 1'b1);
        msg[0] = '1; msg[1] = '1; msg[2] = '1;
        send_msg(3, 0, 1'b1);

        // R2: random lengths, no gaps, consecutive messages
        for (int m = 0; m < 40; m++) begin
            int n = $urandom_range(MAXB, 1);
            fill_random(n);
            send_msg(n, 0, 1'b1);
        end
        // R8: random lengths with idle gaps
        for (int m = 0; m < 20; m++) begin
            int n = $urandom_range(8, 1);
            fill_random(n);
            send_msg(n, 3, 1'b1);
        end

        // R4: abandoned message, then a fresh start
        for (int i = 0; i < 3; i++) begin
            valid_i = 1'b1; start_i = (i == 0); last_i = 1'b0;
            data_i = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
        end
        valid_i = 1'b0; start_i = 1'b0;
        fill_random(4);
        send_msg(4, 0, 1'b1);

        // R5: partial message, bare clear, message without start
        repeat (3) @(negedge clk);
        valid_i = 1'b1; data_i = '1;
        @(negedge clk);
        valid_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check(crc_o == 32'h0, "R5 crc after clear", crc_o, 32'h0);
        fill_random(3);
        send_msg(3, 0, 1'b0);

        // R6: crc holds while idle
        repeat (3) @(negedge clk);
        held = crc_o;
        repeat (6) @(negedge clk);
        check(crc_o == held, "R6 crc held idle", crc_o, held);
        check(crc_o == exp_crc[wr-1], "R6 crc keeps final value", crc_o, exp_crc[wr-1]);

        // R3: one done per message
        check(rd == wr, "R3 done count", rd, wr);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule